// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block decides which interrupt a small processor core services next. It watches six maskable request lines and one management event. The management event is non-maskable and always ranks highest. Each maskable source carries a 2-bit software level. A request can only compete when its level is strictly above the core's current level. The highest level wins. When levels are equal, a fixed hardware order breaks the tie, and a lower source index ranks higher. When the controller grants a request it raises a one-cycle take strobe and presents the vector index. On entry it saves the old core level on a small internal stack and raises the core level. A return-from-interrupt pulse restores the saved level.

A mode input chooses how handlers interact. In concurrent mode a running handler is never preempted by a maskable source. In nested mode a request whose level is strictly higher preempts the running handler. The block also tracks Wait and Halt sleep states. Any eligible request ends Wait. Only sources flagged as Halt-capable, or the management event, end Halt. After a Halt exit the first grant is restricted to capable sources. A stronger non-capable request is granted only after that first handler returns.

Top module: `nic_prio_ctrl`

## Requirements
- R1: After reset the core level is 2'b10, awake_o is 1 and take_o is 0.
- R2: A maskable source i is eligible only when req_i[i] is 1 and its level src_lvl_i[2i+1:2i] is strictly greater than core_lvl_o. A core level of 2'b11 therefore masks every maskable source.
- R3: Among eligible sources, the one with the highest level is granted. At equal levels the lowest index wins. vec_o carries the source index 0..5.
- R4: A pulse on mgmt_i leaves a pending management event. It is granted with vec_o = 6 ahead of every maskable source, even at core level 2'b11 and inside a concurrent-mode handler. After it, the core level becomes 2'b11.
- R5: In the cycle after take_o, core_lvl_o equals the granted source's level, and the previous level has been pushed on the stack.
- R6: An iret_i pulse restores the most recently saved level in the next cycle. An iret_i with no saved level leaves core_lvl_o unchanged.
- R7: In concurrent mode (nested_i = 0), no maskable source is granted while at least one handler is active.
- R8: In nested mode (nested_i = 1), a request whose level is strictly above the running handler's level preempts it. A request at an equal level does not.
- R9: A wait_i pulse puts the core to sleep (awake_o = 0). Any eligible request or a pending management event wakes it in the next cycle, and the grant follows one cycle later. No grant occurs while the core is asleep.
- R10: A halt_i pulse puts the core to sleep. Only an eligible request whose halt_cap_i bit is 1, or a pending management event, wakes it.
- R11: After a Halt wake, only Halt-capable sources (and the management event) can be granted until the first iret_i. After that, normal selection resumes.
- R12: The stack holds 4 levels and wraps silently. A fifth push overwrites the oldest slot, so later pops return the overwritten value. No error is signalled.
- R13: lvl_wr_i loads lvl_wdata_i into the core level. In a cycle where iret_i, lvl_wr_i, wait_i or halt_i is high, no grant is made, and the core level changes only through those inputs or a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nested_i | input | 1 | 1 = nested preemption, 0 = concurrent |
| req_i | input | 6 | Maskable request lines |
| src_lvl_i | input | 12 | 2-bit software level per source, source i at bits 2i+1:2i |
| halt_cap_i | input | 6 | Source may end Halt |
| mgmt_i | input | 1 | Management event pulse |
| iret_i | input | 1 | Return-from-interrupt pulse |
| lvl_wr_i | input | 1 | Core level write strobe |
| lvl_wdata_i | input | 2 | Core level write value |
| wait_i | input | 1 | Enter Wait |
| halt_i | input | 1 | Enter Halt |
| take_o | output | 1 | Grant strobe |
| vec_o | output | 3 | Granted vector index (6 = management event) |
| core_lvl_o | output | 2 | Current core level |
| awake_o | output | 1 | Core is running |

## Verification
The bench sweeps every request pattern across eight level layouts and all four core levels. It compares each grant with a selection model of its own. This sweep catches a tie-break reversed in hardware order, and it catches a `>=` mask that admits equal-level requests. Directed sequences cover the remaining cases:
- Preemption in both modes, including the management event breaking into a concurrent handler. A design that ignored the mode would preempt there, or would stall the event.
- The Halt-exit order. A design without the capability filter would grant the stronger non-capable source first, or would wake on it.
- Five nested entries followed by five returns. A stack that saturated instead of wrapping would restore level 0 in place of 3 at the last pop.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int LVL_W = 2;
  typedef enum logic [1:0] {PM_RUN, PM_WAIT, PM_HALT} pmode_e;
endpackage

// File: rtl/nic_select.sv
module nic_select #(
  parameter int N_SRC = 6,
  parameter int LW    = 2,
  parameter int VW    = 3
) (
  input  logic [N_SRC-1:0]    req_i,
  input  logic [N_SRC*LW-1:0] lvl_i,
  input  logic [N_SRC-1:0]    cap_i,
  input  logic [LW-1:0]       core_lvl_i,
  input  logic                filt_i,
  output logic                hit_o,
  output logic [VW-1:0]       vec_o,
  output logic [LW-1:0]       lvl_o,
  output logic                elig_any_o,
  output logic                cap_any_o
);
  logic [N_SRC-1:0] elig, cand;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = req_i[i] && (lvl_i[i*LW +: LW] > core_lvl_i);
    assign cand[i] = elig[i] && (!filt_i || cap_i[i]);
  end

  // scan from lowest hw priority so ties resolve to the lower index
  always_comb begin
    logic          h;
    logic [VW-1:0] v;
    logic [LW-1:0] l;
    h = 1'b0;
    v = '0;
    l = '0;
    for (int i = N_SRC-1; i >= 0; i--) begin
      if (cand[i] && (!h || lvl_i[i*LW +: LW] >= l)) begin
        h = 1'b1;
        v = VW'(i);
        l = lvl_i[i*LW +: LW];
      end
    end
    hit_o = h;
    vec_o = v;
    lvl_o = l;
  end

  assign elig_any_o = |elig;
  assign cap_any_o  = |(elig & cap_i);
endmodule

// File: rtl/nic_lvl_stack.sv
module nic_lvl_stack #(
  parameter int DEPTH = 4,
  parameter int LW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [LW-1:0] din_i,
  output logic [LW-1:0] dout_o,
  output logic          nz_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [LW-1:0] mem_q [DEPTH];
  logic [PW-1:0] ptr_q, rd_idx, wr_nxt;
  logic [CW-1:0] cnt_q;
  logic          pop_ok;

  assign rd_idx = (ptr_q == '0) ? PW'(DEPTH-1) : ptr_q - 1'b1;
  assign wr_nxt = (ptr_q == PW'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
  assign nz_o   = (cnt_q != '0);
  assign pop_ok = pop_i && nz_o;
  assign dout_o = mem_q[rd_idx];

  // pointer wraps silently; overflow overwrites the oldest slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= din_i;
      ptr_q        <= wr_nxt;
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end else if (pop_ok) begin
      ptr_q <= rd_idx;
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nic_pwr.sv
module nic_pwr
  import nic_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic halt_i,
  input  logic wake_any_i,
  input  logic wake_cap_i,
  output logic awake_o,
  output logic halt_wake_o
);
  pmode_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PM_RUN:  if (halt_i) st_d = PM_HALT;
               else if (wait_i) st_d = PM_WAIT;
      PM_WAIT: if (wake_any_i) st_d = PM_RUN;
      PM_HALT: if (wake_cap_i) st_d = PM_RUN;
      default: st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PM_RUN;
    else         st_q <= st_d;
  end

  assign awake_o     = (st_q == PM_RUN);
  assign halt_wake_o = (st_q == PM_HALT) && wake_cap_i;
endmodule

// File: rtl/nic_prio_ctrl.sv
module nic_prio_ctrl
  import nic_pkg::*;
#(
  parameter int           N_SRC   = 6,
  parameter int           DEPTH   = 4,
  parameter logic [1:0]   RST_LVL = 2'b10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       nested_i,
  input  logic [N_SRC-1:0]           req_i,
  input  logic [N_SRC*2-1:0]         src_lvl_i,
  input  logic [N_SRC-1:0]           halt_cap_i,
  input  logic                       mgmt_i,
  input  logic                       iret_i,
  input  logic                       lvl_wr_i,
  input  logic [1:0]                 lvl_wdata_i,
  input  logic                       wait_i,
  input  logic                       halt_i,
  output logic                       take_o,
  output logic [$clog2(N_SRC+1)-1:0] vec_o,
  output logic [1:0]                 core_lvl_o,
  output logic                       awake_o
);
  localparam int VW = $clog2(N_SRC+1);

  logic [LVL_W-1:0] lvl_q, sel_lvl, pop_lvl;
  logic [VW-1:0]    sel_vec;
  logic             sel_hit, elig_any, cap_any;
  logic             mgmt_q, hx_q, halt_wake, stk_nz, cpu_op, ret_ok;

  nic_select #(.N_SRC(N_SRC), .LW(LVL_W), .VW(VW)) u_sel (
    .req_i      (req_i),
    .lvl_i      (src_lvl_i),
    .cap_i      (halt_cap_i),
    .core_lvl_i (lvl_q),
    .filt_i     (hx_q),
    .hit_o      (sel_hit),
    .vec_o      (sel_vec),
    .lvl_o      (sel_lvl),
    .elig_any_o (elig_any),
    .cap_any_o  (cap_any)
  );

  nic_pwr u_pwr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wait_i      (wait_i),
    .halt_i      (halt_i),
    .wake_any_i  (elig_any || mgmt_q),
    .wake_cap_i  (cap_any || mgmt_q),
    .awake_o     (awake_o),
    .halt_wake_o (halt_wake)
  );

  // core-side operations own the cycle; no grant alongside them
  assign cpu_op = iret_i || lvl_wr_i || wait_i || halt_i;
  assign ret_ok = awake_o && iret_i && stk_nz;
  assign take_o = awake_o && !cpu_op &&
                  (mgmt_q || (sel_hit && (nested_i || !stk_nz)));
  assign vec_o  = mgmt_q ? VW'(N_SRC) : sel_vec;

  nic_lvl_stack #(.DEPTH(DEPTH), .LW(LVL_W)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (take_o),
    .pop_i  (awake_o && iret_i),
    .din_i  (lvl_q),
    .dout_o (pop_lvl),
    .nz_o   (stk_nz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= RST_LVL;
      mgmt_q <= 1'b0;
      hx_q   <= 1'b0;
    end else begin
      mgmt_q <= mgmt_i || (mgmt_q && !take_o);
      if (take_o)                    lvl_q <= mgmt_q ? '1 : sel_lvl;
      else if (ret_ok)               lvl_q <= pop_lvl;
      else if (awake_o && lvl_wr_i)  lvl_q <= lvl_wdata_i;
      // capability filter lasts until the first handler returns
      if (halt_wake)                 hx_q <= 1'b1;
      else if (awake_o && iret_i)    hx_q <= 1'b0;
    end
  end

  assign core_lvl_o = lvl_q;
endmodule

// File: rtl/nic_prio_ctrl_chk.sv
module nic_prio_ctrl_chk #(
  parameter int N_SRC = 6,
  parameter int VW    = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               nested_i,
  input logic [N_SRC*2-1:0] src_lvl_i,
  input logic [N_SRC-1:0]   halt_cap_i,
  input logic               iret_i,
  input logic               lvl_wr_i,
  input logic               take_o,
  input logic [VW-1:0]      vec_o,
  input logic [1:0]         core_lvl_o,
  input logic               awake_o,
  input logic               depth_nz_i,
  input logic               hx_i
);
  logic [1:0] taken_lvl;
  logic       taken_cap, is_mgmt;

  always_comb begin
    taken_lvl = '0;
    taken_cap = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (vec_o == VW'(i)) begin
        taken_lvl = src_lvl_i[i*2 +: 2];
        taken_cap = halt_cap_i[i];
      end
    end
  end
  assign is_mgmt = (vec_o == VW'(N_SRC));

  assert_take_awake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> awake_o);
  assert_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !is_mgmt |-> taken_lvl > core_lvl_o);
  assert_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !is_mgmt |=> core_lvl_o == $past(taken_lvl));
  assert_mgmt_lvl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && is_mgmt |=> core_lvl_o == 2'b11);
  assert_conc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nested_i && depth_nz_i && take_o |-> is_mgmt);
  assert_halt_filt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && hx_i && !is_mgmt |-> taken_cap);
  assert_lvl_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o && !iret_i && !lvl_wr_i |=> $stable(core_lvl_o));
endmodule

bind nic_prio_ctrl nic_prio_ctrl_chk #(.N_SRC(N_SRC), .VW(VW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nested_i   (nested_i),
  .src_lvl_i  (src_lvl_i),
  .halt_cap_i (halt_cap_i),
  .iret_i     (iret_i),
  .lvl_wr_i   (lvl_wr_i),
  .take_o     (take_o),
  .vec_o      (vec_o),
  .core_lvl_o (core_lvl_o),
  .awake_o    (awake_o),
  .depth_nz_i (stk_nz),
  .hx_i       (hx_q)
);

// File: tb/nic_prio_ctrl_bench.sv
module nic_prio_ctrl_bench;
  localparam int N = 6;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         nested_i, mgmt_i, iret_i, lvl_wr_i, wait_i, halt_i;
  logic [N-1:0] req_i, halt_cap_i;
  logic [2*N-1:0] src_lvl_i;
  logic [1:0]   lvl_wdata_i, core_lvl_o;
  logic         take_o, awake_o;
  logic [2:0]   vec_o;
  int total = 0, bad = 0;

  always #4 clk_i = ~clk_i;

  nic_prio_ctrl u_nic_prio_ctrl (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int grant();
    return take_o ? int'(vec_o) : 7;
  endfunction

  task automatic nxt();
    @(negedge clk_i);
  endtask

  task automatic wr_core(logic [1:0] v);
    nxt(); lvl_wr_i = 1'b1; lvl_wdata_i = v;
    nxt(); lvl_wr_i = 1'b0;
  endtask

  task automatic iret();
    nxt(); iret_i = 1'b1;
    nxt(); iret_i = 1'b0;
  endtask

  // assert req at this negedge, check grant, drop req next cycle
  task automatic grant_src(int s, int exp, string tag);
    req_i[s] = 1'b1; #2;
    chk(tag, grant(), exp);
    nxt(); req_i[s] = 1'b0;
  endtask

  task automatic pulse_mgmt(string tag);
    nxt(); mgmt_i = 1'b1;
    nxt(); mgmt_i = 1'b0; #2;
    chk(tag, grant(), 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; nested_i = 1'b1; mgmt_i = 1'b0; iret_i = 1'b0;
    lvl_wr_i = 1'b0; wait_i = 1'b0; halt_i = 1'b0; req_i = '0;
    halt_cap_i = '0; src_lvl_i = '0; lvl_wdata_i = '0;
    repeat (3) nxt();
    rst_ni = 1'b1; #2;
    chk("R1 core", int'(core_lvl_o), 2);
    chk("R1 awake", int'(awake_o), 1);
    chk("R1 take", int'(take_o), 0);

    // R2/R3 sweep: every request pattern, 8 level layouts, 4 core levels
    for (int cl = 0; cl < 4; cl++) begin
      wr_core(2'(cl));
      #2 chk("R13 write", int'(core_lvl_o), cl);
      for (int k = 0; k < 8; k++) begin
        for (int p = 0; p < 64; p++) begin
          int lv[N];
          int best, bl;
          nxt();
          for (int i = 0; i < N; i++) begin
            lv[i] = (i * (k + 1) + k) % 4;
            src_lvl_i[2*i +: 2] = 2'(lv[i]);
          end
          req_i = 6'(p);
          best = 7; bl = -1;
          for (int i = 0; i < N; i++)
            if (p[i] && lv[i] > cl && lv[i] > bl) begin best = i; bl = lv[i]; end
          #2 chk("R2 R3 select", grant(), best);
          req_i = '0;
        end
      end
    end
    src_lvl_i = '0;

    // R5 R6 R8: nested entry, preemption, return
    wr_core(2'b00);
    src_lvl_i[5:4] = 2'd1; src_lvl_i[9:8] = 2'd2; src_lvl_i[11:10] = 2'd2;
    nxt(); grant_src(2, 2, "R5 take src2");
    #2 chk("R5 lvl after src2", int'(core_lvl_o), 1);
    nxt(); grant_src(4, 4, "R8 preempt by src4");
    #2 chk("R5 lvl after src4", int'(core_lvl_o), 2);
    nxt(); req_i[5] = 1'b1; #2 chk("R8 equal level blocked", grant(), 7);
    req_i[5] = 1'b0;
    iret(); #2 chk("R6 pop to 1", int'(core_lvl_o), 1);
    iret(); #2 chk("R6 pop to 0", int'(core_lvl_o), 0);
    iret(); #2 chk("R6 empty iret", int'(core_lvl_o), 0);

    // R7 R4: concurrent mode
    nested_i = 1'b0;
    src_lvl_i[9:8] = 2'd3;
    nxt(); grant_src(2, 2, "R7 first take");
    req_i[4] = 1'b1; #2 chk("R7 no preempt", grant(), 7);
    nxt(); #2 chk("R7 still blocked", grant(), 7);
    req_i[4] = 1'b0;
    pulse_mgmt("R4 mgmt in concurrent handler");
    nxt(); #2 chk("R4 mgmt lvl", int'(core_lvl_o), 3);
    req_i[4] = 1'b1;
    iret(); #2 chk("R7 back in src2 handler", grant(), 7);
    iret(); #2 chk("R7 served after return", grant(), 4);
    nxt(); req_i[4] = 1'b0;
    iret(); #2 chk("R6 back to 0", int'(core_lvl_o), 0);
    nested_i = 1'b1;

    // R4 R2: mgmt at core level 3, maskable masked
    wr_core(2'b11);
    nxt(); req_i[0] = 1'b1; src_lvl_i[1:0] = 2'd3; #2 chk("R2 lvl3 masked", grant(), 7);
    req_i[0] = 1'b0;
    pulse_mgmt("R4 mgmt at lvl3");
    iret(); #2 chk("R6 back to 3", int'(core_lvl_o), 3);

    // R9: wait
    wr_core(2'b00);
    nxt(); wait_i = 1'b1;
    nxt(); wait_i = 1'b0; #2 chk("R9 asleep", int'(awake_o), 0);
    nxt(); req_i[2] = 1'b1; #2 chk("R9 no grant asleep", grant(), 7);
    nxt(); #2 chk("R9 woke", int'(awake_o), 1);
    chk("R9 grant after wake", grant(), 2);
    nxt(); req_i[2] = 1'b0;
    iret();

    // R10 R11: halt with capability filter
    src_lvl_i = '0;
    src_lvl_i[3:2] = 2'd3; src_lvl_i[7:6] = 2'd1;
    halt_cap_i = 6'b001000;
    nxt(); halt_i = 1'b1;
    nxt(); halt_i = 1'b0; req_i[1] = 1'b1;
    repeat (3) nxt();
    #2 chk("R10 non-capable no wake", int'(awake_o), 0);
    nxt(); req_i[3] = 1'b1;
    nxt(); #2 chk("R10 capable wake", int'(awake_o), 1);
    chk("R11 first is capable", grant(), 3);
    nxt(); req_i[3] = 1'b0; #2 chk("R11 filtered", grant(), 7);
    nxt(); #2 chk("R11 still filtered", grant(), 7);
    iret(); #2 chk("R11 non-capable after return", grant(), 1);
    nxt(); req_i[1] = 1'b0;
    iret(); #2 chk("R6 after halt seq", int'(core_lvl_o), 0);
    halt_cap_i = '0;

    // R12: five entries into a 4-deep stack
    src_lvl_i = '0;
    src_lvl_i[11:10] = 2'd1; src_lvl_i[9:8] = 2'd2; src_lvl_i[1:0] = 2'd3;
    nxt(); grant_src(5, 5, "R12 e1");
    grant_src(4, 4, "R12 e2");
    grant_src(0, 0, "R12 e3");
    pulse_mgmt("R12 e4");
    pulse_mgmt("R12 e5");
    iret(); #2 chk("R12 pop1", int'(core_lvl_o), 3);
    iret(); #2 chk("R12 pop2", int'(core_lvl_o), 3);
    iret(); #2 chk("R12 pop3", int'(core_lvl_o), 2);
    iret(); #2 chk("R12 pop4", int'(core_lvl_o), 1);
    iret(); #2 chk("R12 pop5 wrapped", int'(core_lvl_o), 3);
    iret(); #2 chk("R12 drained", int'(core_lvl_o), 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule